// File: doc/BRIEF.md
# One-Time-Programmable Security Word Command Controller

This block is a synthesizable behavioural model of the command front end for a 128-bit one-time-programmable security word inside a flash device, plus the 16-bit lock word that guards it. The security word has two 64-bit halves. The factory half is loaded from a parameter at reset and can never be changed. The user half starts erased (all ones) and can be programmed until software locks it.

A host drives command and data cycles through a write strobe, an address, a 16-bit data bus and a byte/word select. It reads results back through a read strobe. A write whose low data byte is a command code either switches the read mode, clears the error flags, or opens a two-cycle sequence. After the controller accepts a program or lock-clear operation, it stays busy for a fixed number of cycles and ignores every write during that time. An 8-bit status byte reports readiness and error flags. Each failure case sets its own set of flags.

Top module: `prot_reg_ctrl`

## Requirements
- R1: After reset the status byte is 0x80. In identifier mode, word 0x80 (lock word) reads 0xFFFE. Words 0x81..0x84 read the factory parameter, least significant 16 bits first. Words 0x85..0x88 read 0xFFFF.
- R2: Command 0x90 selects identifier mode. In that mode a read inside word window 0x80..0x88 returns the stored word, and a read outside it returns 0x0000. Command 0xFF selects array mode, where every read returns 0xFFFF. Read data appears on the clock edge that samples the read strobe.
- R3: Command 0xC0 followed by a second write programs the addressed word in that second write. In word mode the address is a word address and all 16 data bits are used.
- R4: In byte mode the address is a byte address. Address bits above bit 0 give the word, address bit 0 = 1 selects the upper byte, and only data bits 7:0 are programmed. Byte-mode reads return the selected byte zero-extended.
- R5: A program write whose address lies outside the window sets status bit 4 only and changes no stored word.
- R6: A program write to the factory half sets status bits 4 and 1 and changes nothing. The same holds for the user half once lock bit 1 is 0.
- R7: Programming 0xFFFD to word 0x80 clears lock bit 1 and locks the user half. Lock bits that are 0 never return to 1.
- R8: Command 0x60 followed by 0xD0 while the voltage-valid input is high completes without errors. Command 0x60 followed by any other byte sets status bits 5 and 4.
- R9: Command 0x60 followed by 0xD0 while the voltage-valid input is low sets status bits 5 and 3.
- R10: An accepted program or lock-clear operation holds status bit 7 at 0 for BUSY_CYC cycles after its final write. Writes made while busy are ignored.
- R11: Command 0x50 clears status bits 5, 4, 3 and 1.
- R12: Programming only changes stored bits from 1 to 0. The new word is the old word ANDed with the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| rd_en | input | 1 | Read strobe, loads rdata |
| byte_mode | input | 1 | 1 = byte-wide cycles, 0 = word-wide |
| addr | input | ADDR_W (9) | Word address, or byte address in byte mode |
| wdata | input | 16 | Command or program data |
| vpp_ok | input | 1 | Programming voltage valid |
| rdata | output | 16 | Registered read data |
| status | output | 8 | Status: bit7 ready, bits 5/4/3/1 error flags |

## Verification
A corrupted lock word or sequence state shows up at the ports within one write. The next program attempt either lands where it should be refused, raising no bit 1, or is refused wrongly with status 0x92. A read-back in identifier mode one cycle later exposes any stored word that moved. A stuck busy counter shows on status bit 7 within BUSY_CYC cycles. A lost write shows as an unchanged word on the following read.

// File: rtl/prot_pkg.sv
// Package: command codes and sequencing state shared by the controller.
package prot_pkg;
    localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;
    localparam logic [7:0] CMD_READ_ID    = 8'h90;
    localparam logic [7:0] CMD_CLR_STATUS = 8'h50;
    localparam logic [7:0] CMD_PGM_SETUP  = 8'hC0;
    localparam logic [7:0] CMD_CLR_SETUP  = 8'h60;
    localparam logic [7:0] CMD_CONFIRM    = 8'hD0;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_PGM,
        SEQ_CLR
    } seq_t;
endpackage

// File: rtl/prot_busy_timer.sv
// Busy timer: once started, reports busy for exactly BUSY_CYC cycles.
// Assumes start is never raised while already busy (the caller gates it).
module prot_busy_timer #(
    parameter int BUSY_CYC = 4,
    localparam int CW = $clog2(BUSY_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    logic [CW-1:0] cnt;

    // Load on start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (start)
            cnt <= CW'(BUSY_CYC);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/prot_store.sv
// Storage: the lock word (index 0), the factory half (1..SEG_WORDS) and the
// user half (the remaining words). Programming ANDs the data into one word.
// Assumes the caller has already checked the legality of every program.
module prot_store #(
    parameter int          DW         = 16,
    parameter int          SEG_WORDS  = 4,
    parameter logic [63:0] FACTORY_ID = 64'h0123_4567_89AB_CDEF,
    localparam int         NW         = 1 + 2 * SEG_WORDS,
    localparam int         RW         = $clog2(NW)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pgm_en,
    input  logic [RW-1:0]          pgm_rel,
    input  logic [DW-1:0]          pgm_data,
    output logic [NW-1:0][DW-1:0]  words
);
    localparam logic [DW-1:0] LOCK_INIT = {{(DW-1){1'b1}}, 1'b0};

    for (genvar w = 0; w < NW; w++) begin : g_word
        localparam int FI = (w >= 1 && w <= SEG_WORDS) ? w - 1 : 0;
        localparam logic [DW-1:0] INIT =
            (w == 0)          ? LOCK_INIT :
            (w <= SEG_WORDS)  ? FACTORY_ID[FI*DW +: DW] : {DW{1'b1}};

        // Reset to the initial image; an accepted program may only clear bits.
        always_ff @(posedge clk) begin
            if (!rst_n)
                words[w] <= INIT;
            else if (pgm_en && pgm_rel == RW'(w))
                words[w] <= words[w] & pgm_data;
        end
    end
endmodule

// File: rtl/prot_cmd_fsm.sv
// Command decoder: one-write commands, the two-cycle program and lock-clear
// sequences, lock enforcement and the error flags.
// Assumes in_win/rel already decode the write address into the window.
module prot_cmd_fsm #(
    parameter int  SEG_WORDS = 4,
    localparam int NW        = 1 + 2 * SEG_WORDS,
    localparam int RW        = $clog2(NW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          busy,
    input  logic [7:0]    cmd,
    input  logic          in_win,
    input  logic [RW-1:0] rel,
    input  logic [1:0]    lock_bits,
    input  logic          vpp_ok,
    output logic          pgm_en,
    output logic          start_busy,
    output logic          id_mode,
    output logic          err1,
    output logic          err3,
    output logic          err4,
    output logic          err5
);
    import prot_pkg::*;

    seq_t seq;
    logic wr_ok;
    logic tgt_locked;

    assign wr_ok = wr_en && !busy;

    // Whether the addressed window word belongs to a locked segment.
    always_comb begin
        if (rel == '0)
            tgt_locked = 1'b0;
        else if (rel <= RW'(SEG_WORDS))
            tgt_locked = !lock_bits[0];
        else
            tgt_locked = !lock_bits[1];
    end

    // Pulse outputs for the second write of a program sequence.
    always_comb begin
        pgm_en     = wr_ok && seq == SEQ_PGM && in_win && !tgt_locked;
        start_busy = pgm_en ||
                     (wr_ok && seq == SEQ_CLR && cmd == CMD_CONFIRM && vpp_ok);
    end

    // Sequence state, read mode and error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq     <= SEQ_IDLE;
            id_mode <= 1'b0;
            err1    <= 1'b0;
            err3    <= 1'b0;
            err4    <= 1'b0;
            err5    <= 1'b0;
        end else if (wr_ok) begin
            case (seq)
                SEQ_PGM: begin
                    seq <= SEQ_IDLE;
                    if (!in_win) begin
                        err4 <= 1'b1;
                    end else if (tgt_locked) begin
                        err4 <= 1'b1;
                        err1 <= 1'b1;
                    end
                end
                SEQ_CLR: begin
                    seq <= SEQ_IDLE;
                    if (cmd != CMD_CONFIRM) begin
                        err4 <= 1'b1;
                        err5 <= 1'b1;
                    end else if (!vpp_ok) begin
                        err3 <= 1'b1;
                        err5 <= 1'b1;
                    end
                end
                default: begin
                    case (cmd)
                        CMD_READ_ARRAY: id_mode <= 1'b0;
                        CMD_READ_ID:    id_mode <= 1'b1;
                        CMD_PGM_SETUP:  seq <= SEQ_PGM;
                        CMD_CLR_SETUP:  seq <= SEQ_CLR;
                        CMD_CLR_STATUS: begin
                            err1 <= 1'b0;
                            err3 <= 1'b0;
                            err4 <= 1'b0;
                            err5 <= 1'b0;
                        end
                        default: ;
                    endcase
                end
            endcase
        end
    end
endmodule

// File: rtl/prot_reg_ctrl.sv
// Top: address decode into the security-word window, byte/word lane
// handling, read path and status byte. Window base is a word address.
// Assumes one bus cycle per strobe and that reads and writes do not overlap.
module prot_reg_ctrl #(
    parameter int          ADDR_W     = 9,
    parameter int          DW         = 16,
    parameter int          SEG_WORDS  = 4,
    parameter int          LOCK_OFS   = 'h80,
    parameter int          BUSY_CYC   = 4,
    parameter logic [63:0] FACTORY_ID = 64'h0123_4567_89AB_CDEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              byte_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic              vpp_ok,
    output logic [DW-1:0]     rdata,
    output logic [7:0]        status
);
    localparam int NW = 1 + 2 * SEG_WORDS;
    localparam int RW = $clog2(NW);
    localparam logic [ADDR_W-1:0] WIN_LO = ADDR_W'(LOCK_OFS);
    localparam logic [ADDR_W-1:0] WIN_HI = ADDR_W'(LOCK_OFS + NW - 1);
    localparam int HB = DW / 2;

    logic [ADDR_W-1:0]     word_idx;
    logic                  in_win;
    logic [RW-1:0]         rel;
    logic [DW-1:0]         pgm_data;
    logic [DW-1:0]         sel_word;
    logic [NW-1:0][DW-1:0] words;
    logic                  pgm_en, start_busy, busy, id_mode;
    logic                  err1, err3, err4, err5;

    // Address to word index and window-relative offset.
    always_comb begin
        word_idx = byte_mode ? {1'b0, addr[ADDR_W-1:1]} : addr;
        in_win   = (word_idx >= WIN_LO) && (word_idx <= WIN_HI);
        rel      = in_win ? RW'(word_idx - WIN_LO) : '0;
    end

    // Program data mask: in byte mode the other lane is left all ones.
    always_comb begin
        if (!byte_mode)
            pgm_data = wdata;
        else if (addr[0])
            pgm_data = {wdata[HB-1:0], {HB{1'b1}}};
        else
            pgm_data = {{HB{1'b1}}, wdata[HB-1:0]};
    end

    prot_cmd_fsm #(.SEG_WORDS(SEG_WORDS)) i_fsm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .busy(busy),
        .cmd(wdata[7:0]), .in_win(in_win), .rel(rel),
        .lock_bits(words[0][1:0]), .vpp_ok(vpp_ok),
        .pgm_en(pgm_en), .start_busy(start_busy), .id_mode(id_mode),
        .err1(err1), .err3(err3), .err4(err4), .err5(err5)
    );

    prot_store #(.DW(DW), .SEG_WORDS(SEG_WORDS), .FACTORY_ID(FACTORY_ID)) i_store (
        .clk(clk), .rst_n(rst_n), .pgm_en(pgm_en), .pgm_rel(rel),
        .pgm_data(pgm_data), .words(words)
    );

    prot_busy_timer #(.BUSY_CYC(BUSY_CYC)) i_busy (
        .clk(clk), .rst_n(rst_n), .start(start_busy), .busy(busy)
    );

    // Lane select for byte-mode reads.
    always_comb begin
        sel_word = words[rel];
        if (byte_mode)
            sel_word = addr[0] ? {{HB{1'b0}}, sel_word[DW-1:HB]}
                               : {{HB{1'b0}}, sel_word[HB-1:0]};
    end

    // Registered read data, chosen by the current read mode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en)
            rdata <= !id_mode ? {DW{1'b1}} : (in_win ? sel_word : '0);
    end

    assign status = {!busy, 1'b0, err5, err4, err3, 1'b0, err1, 1'b0};
endmodule

// File: rtl/prot_reg_ctrl_chk.sv
// Checker: temporal rules on the stored words and the status byte.
module prot_reg_ctrl_chk #(
    parameter int  DW        = 16,
    parameter int  SEG_WORDS = 4,
    localparam int NW        = 1 + 2 * SEG_WORDS
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic                  busy,
    input logic [NW-1:0][DW-1:0] words,
    input logic [7:0]            status
);
    AST_LOCK_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
        (~$past(words[0]) & words[0]) == '0); // R7
    AST_USER_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
        (~$past(words[NW-1:SEG_WORDS+1]) & words[NW-1:SEG_WORDS+1]) == '0); // R12
    AST_FACTORY_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(words[SEG_WORDS:1])); // R6
    AST_LOCKED_USER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !words[0][1] |=> $stable(words[NW-1:SEG_WORDS+1])); // R6
    AST_BUSY_IGNORES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        busy && wr_en |=> $stable(words) && $stable(status[5:1])); // R10
    AST_ERROR_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[4]) |-> $stable(words)); // R5
endmodule

bind prot_reg_ctrl prot_reg_ctrl_chk #(.DW(DW), .SEG_WORDS(SEG_WORDS)) i_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .busy(busy),
    .words(words), .status(status)
);

// File: tb/test_prot_reg_ctrl.sv
module test_prot_reg_ctrl;
    localparam int          BUSY_CYC = 4;
    localparam logic [63:0] FID      = 64'h0123_4567_89AB_CDEF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0, byte_mode = 1'b0, vpp_ok = 1'b1;
    logic [8:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [7:0]  status;
    int          errors = 0, checks = 0;

    always #4 clk = ~clk;

    prot_reg_ctrl #(.BUSY_CYC(BUSY_CYC), .FACTORY_ID(FID)) i_prot_reg_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .byte_mode(byte_mode), .addr(addr), .wdata(wdata), .vpp_ok(vpp_ok),
        .rdata(rdata), .status(status)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [15:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [15:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; d = rdata;
    endtask

    task automatic wait_ready();
        repeat (BUSY_CYC) @(negedge clk);
    endtask

    task automatic pgm(input logic [8:0] a, input logic [15:0] d);
        wr(9'h000, 16'h00C0); wr(a, d);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        check("R1 status", {8'h0, status}, 16'h0080);
        wr(9'h000, 16'h0090);
        rd(9'h080, v); check("R1 lock", v, 16'hFFFE);
        rd(9'h081, v); check("R1 factory lo", v, FID[15:0]);
        rd(9'h084, v); check("R1 factory hi", v, FID[63:48]);
        rd(9'h085, v); check("R1 user", v, 16'hFFFF);
    endtask

    task automatic t_modes();
        logic [15:0] v;
        rd(9'h040, v); check("R2 outside window", v, 16'h0000);
        wr(9'h000, 16'h00FF);
        rd(9'h081, v); check("R2 array mode", v, 16'hFFFF);
        wr(9'h000, 16'h0090);
        rd(9'h082, v); check("R2 id mode again", v, FID[31:16]);
    endtask

    task automatic t_program();
        logic [15:0] v;
        pgm(9'h085, 16'h1234);
        check("R10 busy after program", {15'h0, status[7]}, 16'h0000);
        wait_ready();
        check("R10 ready again", {8'h0, status}, 16'h0080);
        rd(9'h085, v); check("R3 word program", v, 16'h1234);
        pgm(9'h085, 16'hFF00); wait_ready();
        rd(9'h085, v); check("R12 and-only", v, 16'h1200);
        pgm(9'h085, 16'hFFFF); wait_ready();
        rd(9'h085, v); check("R12 no 0 to 1", v, 16'h1200);
    endtask

    task automatic t_busy_ignore();
        logic [15:0] v;
        pgm(9'h087, 16'hAAAA);
        wr(9'h000, 16'h00C0);
        wait_ready();
        wr(9'h088, 16'h0000);
        wait_ready();
        rd(9'h088, v); check("R10 write while busy ignored", v, 16'hFFFF);
        rd(9'h087, v); check("R3 programmed", v, 16'hAAAA);
    endtask

    task automatic t_byte();
        logic [15:0] v;
        byte_mode = 1'b1;
        pgm(9'h10D, 16'h003C); wait_ready();
        pgm(9'h10C, 16'h005A); wait_ready();
        rd(9'h10D, v); check("R4 byte read hi", v, 16'h003C);
        rd(9'h10C, v); check("R4 byte read lo", v, 16'h005A);
        byte_mode = 1'b0;
        rd(9'h086, v); check("R4 word view", v, 16'h3C5A);
    endtask

    task automatic t_range();
        logic [15:0] v;
        pgm(9'h090, 16'h0000);
        check("R5 out of window", {8'h0, status}, 16'h0090);
        rd(9'h088, v); check("R5 no change", v, 16'hFFFF);
        wr(9'h000, 16'h0050);
        check("R11 clear status", {8'h0, status}, 16'h0080);
    endtask

    task automatic t_factory();
        logic [15:0] v;
        pgm(9'h082, 16'h0000);
        check("R6 factory locked", {8'h0, status}, 16'h0092);
        rd(9'h082, v); check("R6 factory kept", v, FID[31:16]);
        wr(9'h000, 16'h0050);
    endtask

    task automatic t_clear_lock();
        wr(9'h000, 16'h0060); wr(9'h000, 16'h00D0);
        check("R8 confirm busy", {8'h0, status}, 16'h0000);
        wait_ready();
        check("R8 confirm ok", {8'h0, status}, 16'h0080);
        wr(9'h000, 16'h0060); wr(9'h000, 16'h0033);
        check("R8 bad confirm", {8'h0, status}, 16'h00B0);
        wr(9'h000, 16'h0050);
        vpp_ok = 1'b0;
        wr(9'h000, 16'h0060); wr(9'h000, 16'h00D0);
        check("R9 voltage invalid", {8'h0, status}, 16'h00A8);
        vpp_ok = 1'b1;
        wr(9'h000, 16'h0050);
        check("R11 clear after R9", {8'h0, status}, 16'h0080);
    endtask

    task automatic t_lock();
        logic [15:0] v;
        pgm(9'h080, 16'hFFFD); wait_ready();
        rd(9'h080, v); check("R7 lock word", v, 16'hFFFC);
        pgm(9'h080, 16'hFFFF); wait_ready();
        rd(9'h080, v); check("R7 one-way", v, 16'hFFFC);
        pgm(9'h085, 16'h0000);
        check("R6 user locked", {8'h0, status}, 16'h0092);
        rd(9'h085, v); check("R6 user kept", v, 16'h1200);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_modes();
        t_program();
        t_busy_ignore();
        t_byte();
        t_range();
        t_factory();
        t_clear_lock();
        t_lock();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule